// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block sits between two 18-bit data ports, named A and B, and moves data across them in both directions. Each direction has its own storage element. The latch-enable and edge-clock inputs of that direction choose how the element behaves: it can pass data straight through, hold its present value, or capture data on a rising edge. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. The data path does not invert in either direction.

Tri-state pins are not synthesizable, so each port is split into three vectors: an input, an output and a per-bit output enable. A deasserted enable stands for the high-impedance state. The per-direction edge clocks `clk_ab` and `clk_ba` are ordinary inputs, sampled by the system clock `clk`. A "rising edge" of `clk_ab` means the first `clk` edge at which `clk_ab` is sampled high after it was sampled low. The element stores the data on that same `clk` edge.

Top module: `univ_xcvr`

## Requirements
- R1: While `lat_ab` is 1, `b_out` equals `a_in` bit for bit, combinationally and without inversion, across all 18 bits.
- R2: While `lat_ab` is 0 and `clk_ab` stays at a steady level (held low or held high), the A-to-B stored value and `b_out` do not change, whatever `a_in` does.
- R3: While `lat_ab` is 0, a rising edge of `clk_ab` stores `a_in` as sampled on that `clk` edge, and `b_out` shows it from that edge on. Before that edge, `b_out` keeps the old value.
- R4: While `lat_ab` is 1, a rising edge of `clk_ab` has no effect beyond the pass-through: `b_out` still tracks every later change of `a_in`.
- R5: When `lat_ab` falls, the element keeps the `a_in` value sampled at the last `clk` edge at which `lat_ab` was 1. It holds that value until a `clk_ab` rising edge occurs or `lat_ab` rises again.
- R6: `en_ab` = 1 sets all 18 bits of `b_oe` to 1, and `en_ab` = 0 clears them all.
- R7: The B-to-A path follows R1 to R5 with `lat_ba`, `clk_ba`, `b_in` and `a_out`. `en_ba_n` = 0 sets all bits of `a_oe` to 1, and `en_ba_n` = 1 clears them.
- R8: Activity on one direction's controls or data never changes the value stored by the other direction.
- R9: If both directions are enabled at once, both output-enable vectors are all ones and each output still shows its own path's value. No arbitration takes place.
- R10: While `rst_n` is 0 (asynchronous, active low), both stored values are zero. With both latch enables at 0, `a_out` and `b_out` then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the edge-clock inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Data arriving on port A |
| a_out | output | 18 | Data driven onto port A (B-to-A path) |
| a_oe | output | 18 | Per-bit drive enable for port A |
| b_in | input | 18 | Data arriving on port B |
| b_out | output | 18 | Data driven onto port B (A-to-B path) |
| b_oe | output | 18 | Per-bit drive enable for port B |
| en_ab | input | 1 | A-to-B output enable, active high |
| en_ba_n | input | 1 | B-to-A output enable, active low |
| lat_ab | input | 1 | A-to-B latch enable (1 = pass-through) |
| lat_ba | input | 1 | B-to-A latch enable (1 = pass-through) |
| clk_ab | input | 1 | A-to-B capture clock |
| clk_ba | input | 1 | B-to-A capture clock |

## Verification
The bench holds `clk_ab` high for several cycles while `a_in` changes. A design that triggers on the level instead of the edge would let `b_out` follow the data. It also lowers `lat_ab` and then changes `a_in` right away, which catches a design that keeps tracking the input for one cycle too long. Checks taken just before and just after the sampled capture edge expose an off-by-one capture. Exercising one direction while the other holds data shows up storage or controls that leak across paths. Driving both enables at once reveals a swapped enable polarity or a hidden arbitration scheme.

// File: rtl/univ_xcvr.sv
module univ_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         lat_ab,
  input  logic         lat_ba,
  input  logic         clk_ab,
  input  logic         clk_ba
);

  logic [W-1:0] st_ab, st_ba;
  logic         ck_ab_q, ck_ba_q;
  logic         rise_ab, rise_ba;

  assign rise_ab = clk_ab & ~ck_ab_q;
  assign rise_ba = clk_ba & ~ck_ba_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ab   <= '0;
      ck_ab_q <= 1'b0;
    end else begin
      ck_ab_q <= clk_ab;
      if (lat_ab || rise_ab) st_ab <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ba   <= '0;
      ck_ba_q <= 1'b0;
    end else begin
      ck_ba_q <= clk_ba;
      if (lat_ba || rise_ba) st_ba <= b_in;
    end
  end

  assign b_out = lat_ab ? a_in : st_ab;
  assign a_out = lat_ba ? b_in : st_ba;
  assign b_oe  = {W{en_ab}};
  assign a_oe  = {W{~en_ba_n}};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_ab && !rise_ab) |=> $stable(st_ab));
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_ab && rise_ab) |=> (st_ab == $past(a_in)));
  p_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lat_ab |=> (st_ab == $past(a_in)));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_ba && rise_ba) |=> (st_ba == $past(b_in)));
  p_iso_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_ba && !rise_ba) |=> $stable(st_ba));
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (st_ab == '0 && st_ba == '0));

endmodule

// File: tb/univ_xcvr_bench.sv
`timescale 1ns/1ps
module univ_xcvr_bench;
  localparam int W = 18;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic en_ab = 0, en_ba_n = 1, lat_ab = 0, lat_ba = 0, clk_ab = 0, clk_ba = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  univ_xcvr #(.W(W)) u_univ_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .lat_ab(lat_ab), .lat_ba(lat_ba), .clk_ab(clk_ab), .clk_ba(clk_ba));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic t_reset;
    chk("R10 b_out in reset", b_out, '0);
    chk("R10 a_out in reset", a_out, '0);
    chk("R6 b_oe off", b_oe, '0);
    chk("R7 a_oe off", a_oe, '0);
  endtask

  task automatic t_transparent;
    lat_ab = 1; a_in = 18'h2A5C3; #0.5;
    chk("R1 pass pattern1", b_out, 18'h2A5C3);
    a_in = 18'h15A3C; #0.5;
    chk("R1 pass pattern2", b_out, 18'h15A3C);
    a_in = 18'h3FFFF; #0.5;
    chk("R1 pass all ones", b_out, 18'h3FFFF);
  endtask

  task automatic t_latch_fall;
    lat_ab = 1; a_in = 18'h0C0DE; step();
    lat_ab = 0; a_in = 18'h31111; #0.5;
    chk("R5 hold after fall", b_out, 18'h0C0DE);
    step(2);
    chk("R5 still held", b_out, 18'h0C0DE);
  endtask

  task automatic t_hold_capture;
    clk_ab = 0; a_in = 18'h01234; step();
    a_in = 18'h2BEEF; step(2);
    chk("R2 hold clock low", b_out, 18'h0C0DE);
    clk_ab = 1; #0.5;
    chk("R3 before sampling edge", b_out, 18'h0C0DE);
    step();
    chk("R3 captured", b_out, 18'h2BEEF);
    a_in = 18'h00777; step(3);
    chk("R2 hold clock high", b_out, 18'h2BEEF);
    clk_ab = 0; step(); a_in = 18'h1ABCD; step();
    chk("R2 falling edge ignored", b_out, 18'h2BEEF);
    clk_ab = 1; step();
    chk("R3 second capture", b_out, 18'h1ABCD);
    clk_ab = 0; step();
  endtask

  task automatic t_le_clk;
    lat_ab = 1; a_in = 18'h05555; step();
    clk_ab = 1; step();
    a_in = 18'h0AAAA; #0.5;
    chk("R4 still transparent", b_out, 18'h0AAAA);
    step(); lat_ab = 0; a_in = 18'h00001; step(2);
    chk("R4 no late capture", b_out, 18'h0AAAA);
    clk_ab = 0; step();
  endtask

  task automatic t_oe;
    en_ab = 1; #0.5;
    chk("R6 b_oe on", b_oe, '1);
    en_ab = 0; #0.5;
    chk("R6 b_oe off", b_oe, '0);
  endtask

  task automatic t_ba;
    lat_ba = 1; b_in = 18'h1F00F; #0.5;
    chk("R7 pass", a_out, 18'h1F00F);
    step(); lat_ba = 0; b_in = 18'h00F0F; step(2);
    chk("R7 hold", a_out, 18'h1F00F);
    clk_ba = 1; step();
    chk("R7 capture", a_out, 18'h00F0F);
    b_in = 18'h3C3C3; step(2);
    chk("R7 hold high", a_out, 18'h00F0F);
    clk_ba = 0; step();
    en_ba_n = 0; #0.5;
    chk("R7 a_oe on", a_oe, '1);
    en_ba_n = 1; #0.5;
    chk("R7 a_oe off", a_oe, '0);
  endtask

  task automatic t_iso;
    lat_ab = 0; lat_ba = 0;
    b_in = 18'h12121; clk_ba = 1; step(); clk_ba = 0;
    chk("R8 ab kept", b_out, 18'h0AAAA);
    a_in = 18'h34343; clk_ab = 1; step(); clk_ab = 0;
    lat_ab = 1; a_in = 18'h3FFFF; step(); lat_ab = 0; step();
    chk("R8 ba kept", a_out, 18'h12121);
    chk("R8 ab updated", b_out, 18'h3FFFF);
  endtask

  task automatic t_both;
    en_ab = 1; en_ba_n = 0; #0.5;
    if ((&a_oe) && (&b_oe)) $display("[TB] note: bus contention, both ports driving");
    chk("R9 b_oe", b_oe, '1);
    chk("R9 a_oe", a_oe, '1);
    chk("R9 b_out own path", b_out, 18'h3FFFF);
    chk("R9 a_out own path", a_out, 18'h12121);
    en_ab = 0; en_ba_n = 1;
  endtask

  task automatic t_reset_again;
    rst_n = 0; #0.5;
    chk("R10 async clear ab", b_out, '0);
    chk("R10 async clear ba", a_out, '0);
    step(); rst_n = 1; step();
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1; step();
    t_transparent();
    t_latch_fall();
    t_hold_capture();
    t_le_clk();
    t_oe();
    t_ba();
    t_iso();
    t_both();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule